// File: doc/BRIEF.md
# Store-Set Dependence Predictor

This block predicts memory-order dependences between loads and stores so that a load waits only for the stores that have fed it data before, and otherwise issues speculatively. Two small tables carry the learned state. A set table, indexed by low bits of an instruction's PC, gives that instruction a set identifier. A last-store table, indexed by set identifier, holds the tag of the most recently dispatched store of each set that is still waiting for its address.

At dispatch, a load or store looks up its set. If the set's last-store entry is occupied, the dispatching instruction receives that store tag as a dependence to wait on, in the same cycle. A dispatching store also replaces the entry with its own tag, so stores of one set form a chain. When a store's address resolves, its tag is removed from the last-store table if it is still there. When the memory pipeline reports an ordering violation, the training port puts the offending load and store into one shared set. A synchronous flush forgets everything.

Top module: `ssp_predictor`

## Requirements
- R1: After reset, no dispatched load or store receives a dependence, and a dispatching store with no learned set records nothing.
- R2: The set table is indexed by PC bits [7:2]; PCs that differ only outside these bits share an entry.
- R3: A dispatching load whose PC has a learned set, and whose set has a recorded store, gets dep_valid_o = 1 and dep_tag_o equal to that store's tag in the same cycle; dep_valid_o is 0 whenever disp_valid_i is 0.
- R4: A dispatching store with a learned set receives the set's recorded tag (if any) as its own dependence and, from the next cycle, its own tag is the set's recorded tag.
- R5: A resolve of tag T removes T from every set that records it, from the next cycle; a resolve of a tag that no set records changes nothing.
- R6: Training with neither PC in a set allocates a new identifier from a counter that starts at 0 after reset or flush, increments by one per allocation, and wraps from 15 to 0; both PCs get it from the next cycle.
- R7: Training with exactly one of the two PCs in a set gives the other PC that same set.
- R8: Training with both PCs in sets gives both the numerically smaller identifier.
- R9: flush_i invalidates every entry of both tables and resets the allocation counter, effective the next cycle.
- R10: A load or store whose PC has no learned set never receives a dependence.
- R11: When a store of a set dispatches in the same cycle as a resolve of that set's recorded tag (or of its own tag), the dispatching store's tag is what the set records afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous clear of all learned state |
| disp_valid_i | input | 1 | A load or store dispatches this cycle |
| disp_is_store_i | input | 1 | 1 for a store, 0 for a load |
| disp_pc_i | input | 32 | PC of the dispatching instruction |
| disp_tag_i | input | 6 | Tag of the dispatching instruction |
| dep_valid_o | output | 1 | The dispatching instruction must wait on dep_tag_o |
| dep_tag_o | output | 6 | Tag of the store to wait on (0 when dep_valid_o is 0) |
| res_valid_i | input | 1 | A store address has resolved |
| res_tag_i | input | 6 | Tag of the store whose address resolved |
| train_valid_i | input | 1 | An ordering violation is reported |
| train_load_pc_i | input | 32 | PC of the violating load |
| train_store_pc_i | input | 32 | PC of the store it should have waited on |

## Verification
The dependence outputs are combinational from the dispatch inputs and the current table contents, so they are due in the dispatch cycle itself; every table update from a store dispatch, resolve, training report or flush is due one clock edge later. The bench drives each operation on a falling edge, checks the outputs 1 ns later before the next rising edge, and only observes an update through the dispatch that follows it. Sweeps cover every set-table index before and after flush and fill every set identifier, including the allocator's wrap.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    SRC_ALLOC = 2'd0,
    SRC_LOAD  = 2'd1,
    SRC_STORE = 2'd2
  } id_src_e;

  // which identifier a violating pair ends up sharing
  function automatic id_src_e pick_src(input logic load_hit, input logic store_hit,
                                       input logic load_lower);
    if (load_hit && store_hit) return load_lower ? SRC_LOAD : SRC_STORE;
    if (load_hit)              return SRC_LOAD;
    if (store_hit)             return SRC_STORE;
    return SRC_ALLOC;
  endfunction

endpackage

// File: rtl/ssp_pc_table.sv
module ssp_pc_table #(
  parameter int DEPTH    = 64,
  parameter int ID_W     = 4,
  parameter int RD_PORTS = 3,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                clear_i,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]      rd_idx_i,
  output logic [RD_PORTS-1:0]                 rd_hit_o,
  output logic [RD_PORTS-1:0][ID_W-1:0]       rd_id_o,
  input  logic                                wr_en_i,
  input  logic [IDX_W-1:0]                    wr_a_idx_i,
  input  logic [IDX_W-1:0]                    wr_b_idx_i,
  input  logic [ID_W-1:0]                     wr_id_i
);

  logic [DEPTH-1:0]           vld_q;
  logic [DEPTH-1:0][ID_W-1:0] id_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (wr_a_idx_i == IDX_W'(e) || wr_b_idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e] <= 1'b0;
        id_q[e]  <= '0;
      end else if (clear_i) begin
        vld_q[e] <= 1'b0;
      end else if (sel) begin
        vld_q[e] <= 1'b1;
        id_q[e]  <= wr_id_i;
      end
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_hit_o[p] = vld_q[rd_idx_i[p]];
    assign rd_id_o[p]  = id_q[rd_idx_i[p]];
  end

endmodule

// File: rtl/ssp_last_store_table.sv
module ssp_last_store_table #(
  parameter int SETS  = 16,
  parameter int TAG_W = 6,
  localparam int ID_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [ID_W-1:0]  rd_id_i,
  output logic             rd_vld_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             wr_en_i,
  input  logic [ID_W-1:0]  wr_id_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             drop_en_i,
  input  logic [TAG_W-1:0] drop_tag_i
);

  logic [SETS-1:0]            vld_q;
  logic [SETS-1:0][TAG_W-1:0] tag_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic wr_hit, drop_hit;
    assign wr_hit   = wr_en_i && (wr_id_i == ID_W'(s));
    assign drop_hit = drop_en_i && vld_q[s] && (tag_q[s] == drop_tag_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s] <= 1'b0;
        tag_q[s] <= '0;
      end else if (clear_i) begin
        vld_q[s] <= 1'b0;
      end else if (wr_hit) begin
        // a newer store outranks any resolve in the same cycle
        vld_q[s] <= 1'b1;
        tag_q[s] <= wr_tag_i;
      end else if (drop_hit) begin
        vld_q[s] <= 1'b0;
      end
    end
  end

  assign rd_vld_o = vld_q[rd_id_i];
  assign rd_tag_o = tag_q[rd_id_i];

endmodule

// File: rtl/ssp_trainer.sv
module ssp_trainer
  import ssp_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            train_i,
  input  logic            load_hit_i,
  input  logic [ID_W-1:0] load_id_i,
  input  logic            store_hit_i,
  input  logic [ID_W-1:0] store_id_i,
  output logic            wr_en_o,
  output logic [ID_W-1:0] wr_id_o
);

  logic [ID_W-1:0] alloc_q;
  id_src_e         src;

  assign src     = pick_src(load_hit_i, store_hit_i, load_id_i < store_id_i);
  assign wr_en_o = train_i && !clear_i;

  always_comb begin
    unique case (src)
      SRC_LOAD:  wr_id_o = load_id_i;
      SRC_STORE: wr_id_o = store_id_i;
      default:   wr_id_o = alloc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             alloc_q <= '0;
    else if (clear_i)                        alloc_q <= '0;
    else if (train_i && src == SRC_ALLOC)    alloc_q <= alloc_q + 1'b1;
  end

endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor #(
  parameter int PC_W       = 32,
  parameter int PC_LSB     = 2,
  parameter int PC_ENTRIES = 64,
  parameter int SETS       = 16,
  parameter int TAG_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             disp_valid_i,
  input  logic             disp_is_store_i,
  input  logic [PC_W-1:0]  disp_pc_i,
  input  logic [TAG_W-1:0] disp_tag_i,
  output logic             dep_valid_o,
  output logic [TAG_W-1:0] dep_tag_o,
  input  logic             res_valid_i,
  input  logic [TAG_W-1:0] res_tag_i,
  input  logic             train_valid_i,
  input  logic [PC_W-1:0]  train_load_pc_i,
  input  logic [PC_W-1:0]  train_store_pc_i
);

  localparam int IDX_W = $clog2(PC_ENTRIES);
  localparam int ID_W  = $clog2(SETS);
  localparam int P_DSP = 0;
  localparam int P_LD  = 1;
  localparam int P_ST  = 2;

  logic [2:0][IDX_W-1:0] rd_idx;
  logic [2:0]            rd_hit;
  logic [2:0][ID_W-1:0]  rd_id;
  logic                  tr_wr_en;
  logic [ID_W-1:0]       tr_wr_id;
  logic                  disp_set_hit;
  logic                  lst_vld;
  logic [TAG_W-1:0]      lst_tag;
  logic                  lst_wr_en;

  assign rd_idx[P_DSP] = disp_pc_i[PC_LSB +: IDX_W];
  assign rd_idx[P_LD]  = train_load_pc_i[PC_LSB +: IDX_W];
  assign rd_idx[P_ST]  = train_store_pc_i[PC_LSB +: IDX_W];

  ssp_pc_table #(
    .DEPTH    (PC_ENTRIES),
    .ID_W     (ID_W),
    .RD_PORTS (3)
  ) u_pc_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (flush_i),
    .rd_idx_i   (rd_idx),
    .rd_hit_o   (rd_hit),
    .rd_id_o    (rd_id),
    .wr_en_i    (tr_wr_en),
    .wr_a_idx_i (rd_idx[P_LD]),
    .wr_b_idx_i (rd_idx[P_ST]),
    .wr_id_i    (tr_wr_id)
  );

  ssp_trainer #(.ID_W(ID_W)) u_trainer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (flush_i),
    .train_i     (train_valid_i),
    .load_hit_i  (rd_hit[P_LD]),
    .load_id_i   (rd_id[P_LD]),
    .store_hit_i (rd_hit[P_ST]),
    .store_id_i  (rd_id[P_ST]),
    .wr_en_o     (tr_wr_en),
    .wr_id_o     (tr_wr_id)
  );

  assign disp_set_hit = disp_valid_i && rd_hit[P_DSP];
  assign lst_wr_en    = disp_set_hit && disp_is_store_i && !flush_i;

  ssp_last_store_table #(
    .SETS  (SETS),
    .TAG_W (TAG_W)
  ) u_last_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (flush_i),
    .rd_id_i    (rd_id[P_DSP]),
    .rd_vld_o   (lst_vld),
    .rd_tag_o   (lst_tag),
    .wr_en_i    (lst_wr_en),
    .wr_id_i    (rd_id[P_DSP]),
    .wr_tag_i   (disp_tag_i),
    .drop_en_i  (res_valid_i),
    .drop_tag_i (res_tag_i)
  );

  assign dep_valid_o = disp_set_hit && lst_vld;
  assign dep_tag_o   = dep_valid_o ? lst_tag : '0;

endmodule

// File: rtl/ssp_predictor_chk.sv
module ssp_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int TAG_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             disp_valid_i,
  input logic             disp_is_store_i,
  input logic [PC_W-1:0]  disp_pc_i,
  input logic [TAG_W-1:0] disp_tag_i,
  input logic             dep_valid_o,
  input logic [TAG_W-1:0] dep_tag_o,
  input logic             res_valid_i,
  input logic [TAG_W-1:0] res_tag_i,
  input logic             train_valid_i,
  input logic             disp_set_hit
);

  // R9
  flush_forgets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !dep_valid_o);

  // R5
  resolve_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !(disp_valid_i && disp_is_store_i))
      |=> !(dep_valid_o && dep_tag_o == $past(res_tag_i)));

  // R4
  store_records_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && disp_is_store_i && disp_set_hit && !flush_i && !train_valid_i)
      |=> (!(disp_valid_i && disp_pc_i == $past(disp_pc_i))
           || (dep_valid_o && dep_tag_o == $past(disp_tag_i))));

  // R10
  no_set_no_dep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && !disp_set_hit) |-> !dep_valid_o);

  // R3
  dep_needs_disp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dep_valid_o |-> disp_valid_i);

endmodule

bind ssp_predictor ssp_predictor_chk #(.PC_W(PC_W), .TAG_W(TAG_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .flush_i         (flush_i),
  .disp_valid_i    (disp_valid_i),
  .disp_is_store_i (disp_is_store_i),
  .disp_pc_i       (disp_pc_i),
  .disp_tag_i      (disp_tag_i),
  .dep_valid_o     (dep_valid_o),
  .dep_tag_o       (dep_tag_o),
  .res_valid_i     (res_valid_i),
  .res_tag_i       (res_tag_i),
  .train_valid_i   (train_valid_i),
  .disp_set_hit    (disp_set_hit)
);

// File: tb/ssp_predictor_test.sv
`timescale 1ns/1ps
module ssp_predictor_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        dv = 1'b0, dst = 1'b0;
  logic [31:0] dpc = '0;
  logic [5:0]  dtag = '0;
  logic        dep_v;
  logic [5:0]  dep_t;
  logic        rv = 1'b0;
  logic [5:0]  rtag = '0;
  logic        tv = 1'b0;
  logic [31:0] tlpc = '0, tspc = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ssp_predictor uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .disp_valid_i(dv), .disp_is_store_i(dst), .disp_pc_i(dpc), .disp_tag_i(dtag),
    .dep_valid_o(dep_v), .dep_tag_o(dep_t),
    .res_valid_i(rv), .res_tag_i(rtag),
    .train_valid_i(tv), .train_load_pc_i(tlpc), .train_store_pc_i(tspc)
  );

  function automatic logic [31:0] pc_of(input int idx);
    return 32'(idx) << 2;
  endfunction

  task automatic idle();
    dv = 0; dst = 0; rv = 0; tv = 0; flush = 0;
  endtask

  // one cycle: dispatch (optional) with simultaneous resolve (optional)
  task automatic op(input logic st, input logic [31:0] pc, input logic [5:0] tag,
                    input logic r_en, input logic [5:0] r_tag,
                    input logic ev, input logic [5:0] et, input string req);
    @(negedge clk);
    dv = 1; dst = st; dpc = pc; dtag = tag; rv = r_en; rtag = r_tag;
    #1;
    checks++;
    if (dep_v !== ev || dep_t !== (ev ? et : 6'd0)) begin
      errors++;
      $display("FAIL %s pc=%h: actual v=%0b tag=%0d expected v=%0b tag=%0d",
               req, pc, dep_v, dep_t, ev, et);
    end
    @(posedge clk); #1 idle();
  endtask

  task automatic resolve(input logic [5:0] t);
    @(negedge clk); rv = 1; rtag = t;
    @(posedge clk); #1 idle();
  endtask

  task automatic train(input logic [31:0] lpc, input logic [31:0] spc);
    @(negedge clk); tv = 1; tlpc = lpc; tspc = spc;
    @(posedge clk); #1 idle();
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(posedge clk); #1 idle();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 / R10: nothing learned, every index, loads and stores
    for (int i = 0; i < 64; i++) begin
      op(0, pc_of(i), 6'd0, 0, 6'd0, 0, 6'd0, "R1 load after reset");
      op(1, pc_of(i), 6'(i), 0, 6'd0, 0, 6'd0, "R10 store without set");
    end

    // R6: first allocation is set 0
    train(pc_of(1), pc_of(2));
    op(0, pc_of(1), 0, 0, 0, 0, 0, "R1 unset stores recorded nothing");
    op(1, pc_of(2), 6'd5, 0, 0, 0, 0, "R4 first store of set");
    op(0, pc_of(1), 0, 0, 0, 1, 6'd5, "R3 load waits on store");
    op(1, pc_of(2), 6'd7, 0, 0, 1, 6'd5, "R4 store chains on prior store");
    op(0, pc_of(1) + 32'h100, 0, 0, 0, 1, 6'd7, "R2 alias above bit 7");
    op(0, pc_of(1) | 32'h3, 0, 0, 0, 1, 6'd7, "R2 ignore bits below 2");

    // R5
    resolve(6'd3);
    op(0, pc_of(1), 0, 0, 0, 1, 6'd7, "R5 unrelated resolve");
    resolve(6'd7);
    op(0, pc_of(1), 0, 0, 0, 0, 0, "R5 resolve clears");

    // R6: next allocation is set 1, independent of set 0
    train(pc_of(3), pc_of(4));
    op(1, pc_of(4), 6'd9, 0, 0, 0, 0, "R6 new set empty");
    op(0, pc_of(3), 0, 0, 0, 1, 6'd9, "R6 second set");
    op(0, pc_of(1), 0, 0, 0, 0, 0, "R6 sets separate");

    // R7: store joins load's set 0
    train(pc_of(1), pc_of(10));
    op(1, pc_of(10), 6'd11, 0, 0, 0, 0, "R7 joined store");
    op(0, pc_of(1), 0, 0, 0, 1, 6'd11, "R7 load sees joined store");
    op(1, pc_of(2), 6'd12, 0, 0, 1, 6'd11, "R7 old member shares set");

    // R8: load in set 1, store in set 0 -> both set 0
    train(pc_of(3), pc_of(2));
    op(0, pc_of(3), 0, 0, 0, 1, 6'd12, "R8 merged into smaller");
    op(1, pc_of(4), 6'd13, 0, 0, 1, 6'd9, "R8 set 1 untouched");
    op(0, pc_of(3), 0, 0, 0, 1, 6'd12, "R8 load left set 1");

    // R11: same-cycle store dispatch and resolve
    op(1, pc_of(2), 6'd20, 1, 6'd12, 1, 6'd12, "R11 store with resolve of old");
    op(0, pc_of(1), 0, 0, 0, 1, 6'd20, "R11 new tag kept");
    op(1, pc_of(2), 6'd21, 1, 6'd21, 1, 6'd20, "R11 store with resolve of self");
    op(0, pc_of(1), 0, 0, 0, 1, 6'd21, "R11 write wins");

    // R9
    do_flush();
    for (int i = 0; i < 64; i++) begin
      op(1, pc_of(i), 6'd1, 0, 0, 0, 0, "R9 store after flush");
      op(0, pc_of(i), 0, 0, 0, 0, 0, "R9 load after flush");
    end

    // R6 / R9: fill all sets from 0, then wrap
    for (int k = 0; k < 16; k++) train(pc_of(2 * k), pc_of(2 * k + 1));
    for (int k = 0; k < 16; k++)
      op(1, pc_of(2 * k + 1), 6'(k + 32), 0, 0, 0, 0, "R6 fresh set empty");
    for (int k = 0; k < 16; k++)
      op(0, pc_of(2 * k), 0, 0, 0, 1, 6'(k + 32), "R6 distinct sets");
    train(pc_of(40), pc_of(41));
    op(1, pc_of(41), 6'd50, 0, 0, 1, 6'd32, "R6 wrap to set 0");
    op(0, pc_of(0), 0, 0, 0, 1, 6'd50, "R6 wrap shares set 0");
    op(0, pc_of(2), 0, 0, 0, 1, 6'd33, "R6 set 1 intact");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule